// File: doc/BRIEF.md
# Receive Loss-of-Signal Monitor with Data Squelch

This block sits behind a line receiver's clock-recovery stage. It watches the recovered bipolar data, a positive rail and a negative rail. It takes one bit on each cycle in which the recovered-clock enable is high. From this it keeps a loss-of-signal flag. The flag is raised on reset, when a long unbroken run of zero bits arrives, or at once when either of two external conditions is reported: the receive equaliser has reached its top gain, or the analog front end has seen the signal power drop below its threshold.

While the flag is raised, both data rails leaving the block are held low. Downstream framing logic therefore never sees noise as data. Leaving the loss state uses a stricter test than entering it. A fixed-length measurement window of received bits must hold enough ones, and must contain no overlong run of zeros. A run that grows too long throws the window away, and measurement starts again.

The flag appears on a dedicated pin. It is also copied into bit 0 of a small status word, which a register file can map directly.

Top module: `los_detector`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `los_o` is 1 and both data outputs are 0.
- R2: While `los_o` is 0, the flag rises in the cycle after the bit that completes 175 consecutive zero bits; 174 consecutive zeros leave it at 0. A bit is a one when `rx_pos` or `rx_neg` is high, and a zero otherwise.
- R3: In any cycle where `max_gain` or `low_power` is high, whatever `bit_en` does, `los_o` is 1 in the next cycle. While either input is high, the exit window is held empty.
- R4: While `los_o` is 1, `out_pos` and `out_neg` are 0 regardless of the inputs.
- R5: While `los_o` is 0, `out_pos` equals `rx_pos` and `out_neg` equals `rx_neg` in the same cycle.
- R6: While `los_o` is 1, the flag falls in the cycle after the 175th bit of a measurement window that holds at least 22 ones and no run of more than 100 zeros. It never falls in a cycle that follows one with `bit_en` low.
- R7: During loss, a zero that makes the current zero run exceed 100 bits empties the window. Counting restarts with the next bit. A run of exactly 100 zeros does not empty the window.
- R8: A window of 175 bits with only 21 ones leaves `los_o` at 1. A fresh window then begins with the next bit, and a passing fresh window clears the flag.
- R9: `status_o[0]` equals `los_o` in every cycle, and all other bits of `status_o` are 0.
- R10: Cycles with `bit_en` low contribute no bit. Rail values in such cycles neither extend nor break a zero run, and they do not count toward the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Recovered-clock enable; one received bit per high cycle |
| rx_pos | input | 1 | Recovered positive-rail data |
| rx_neg | input | 1 | Recovered negative-rail data |
| max_gain | input | 1 | Receive equaliser is at its maximum gain |
| low_power | input | 1 | Received power is below the analog threshold |
| out_pos | output | 1 | Positive-rail data, squelched during loss |
| out_neg | output | 1 | Negative-rail data, squelched during loss |
| los_o | output | 1 | Loss-of-signal flag (1 = loss) |
| status_o | output | 8 | Status word; bit 0 mirrors the loss flag |

## Verification
Several rules are checked on every cycle by the bound assertions. The reset value of the flag, the squelch of both rails during loss, pass-through while the signal is present, and the one-cycle response to the gain and power inputs are all covered there. So is the rule that the flag moves only after a received bit. Whether the flag moves on exactly the right bit cannot be written as a short property. That covers the 175th zero, the 175th bit of a window, the 21-versus-22 ones boundary, the restart on a 101-zero run against a 100-zero run, and gap cycles carrying stray ones. Those cases are shown only by the bench scenarios, which compare against a behavioural model on every clock.

// File: rtl/los_pkg.sv
package los_pkg;
    localparam int unsigned DEF_ENTRY_ZEROS   = 175;
    localparam int unsigned DEF_WINDOW_BITS   = 175;
    localparam int unsigned DEF_MIN_ONES      = 22;
    localparam int unsigned DEF_MAX_EXIT_RUN  = 100;
    localparam int unsigned DEF_STATUS_W      = 8;

    typedef struct packed {
        logic los;
    } flag_state_t;
endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
    parameter int unsigned ENTRY_ZEROS  = los_pkg::DEF_ENTRY_ZEROS,
    parameter int unsigned MAX_EXIT_RUN = los_pkg::DEF_MAX_EXIT_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic is_one,
    output logic entry_hit,
    output logic long_run
);
    localparam int unsigned RUN_CAP = (ENTRY_ZEROS > MAX_EXIT_RUN) ? ENTRY_ZEROS : (MAX_EXIT_RUN + 1);
    localparam int unsigned RUN_W   = $clog2(RUN_CAP + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            if (is_one) begin
                st_d.run = '0;
            end else if (st_q.run != RUN_W'(RUN_CAP)) begin
                st_d.run = st_q.run + 1'b1;
            end
        end
        entry_hit = bit_en && (st_d.run >= RUN_W'(ENTRY_ZEROS));
        long_run  = bit_en && (st_d.run >  RUN_W'(MAX_EXIT_RUN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/los_exit_window.sv
module los_exit_window #(
    parameter int unsigned WINDOW_BITS = los_pkg::DEF_WINDOW_BITS,
    parameter int unsigned MIN_ONES    = los_pkg::DEF_MIN_ONES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hold,
    input  logic bit_en,
    input  logic is_one,
    input  logic long_run,
    output logic pass
);
    localparam int unsigned CNT_W  = $clog2(WINDOW_BITS + 1);
    localparam int unsigned ONES_W = $clog2(MIN_ONES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  bits;
        logic [ONES_W-1:0] ones;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [CNT_W-1:0]  bits_nx;
    logic [ONES_W-1:0] ones_nx;

    always_comb begin
        st_d    = st_q;
        pass    = 1'b0;
        bits_nx = st_q.bits + 1'b1;
        ones_nx = st_q.ones;
        if (is_one && (st_q.ones != ONES_W'(MIN_ONES))) begin
            ones_nx = st_q.ones + 1'b1;
        end
        if (!active || hold) begin
            st_d = '0;
        end else if (bit_en) begin
            if (long_run) begin
                st_d = '0;
            end else if (bits_nx == CNT_W'(WINDOW_BITS)) begin
                pass = (ones_nx >= ONES_W'(MIN_ONES));
                st_d = '0;
            end else begin
                st_d.bits = bits_nx;
                st_d.ones = ones_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/los_detector.sv
module los_detector #(
    parameter int unsigned ENTRY_ZEROS  = los_pkg::DEF_ENTRY_ZEROS,
    parameter int unsigned WINDOW_BITS  = los_pkg::DEF_WINDOW_BITS,
    parameter int unsigned MIN_ONES     = los_pkg::DEF_MIN_ONES,
    parameter int unsigned MAX_EXIT_RUN = los_pkg::DEF_MAX_EXIT_RUN,
    parameter int unsigned STATUS_W     = los_pkg::DEF_STATUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                rx_pos,
    input  logic                rx_neg,
    input  logic                max_gain,
    input  logic                low_power,
    output logic                out_pos,
    output logic                out_neg,
    output logic                los_o,
    output logic [STATUS_W-1:0] status_o
);
    import los_pkg::*;

    flag_state_t st_d, st_q;
    logic is_one;
    logic forced;
    logic entry_hit;
    logic long_run;
    logic win_pass;

    assign is_one = rx_pos | rx_neg;
    assign forced = max_gain | low_power;

    los_zero_run #(
        .ENTRY_ZEROS (ENTRY_ZEROS),
        .MAX_EXIT_RUN(MAX_EXIT_RUN)
    ) i_zero_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .is_one   (is_one),
        .entry_hit(entry_hit),
        .long_run (long_run)
    );

    los_exit_window #(
        .WINDOW_BITS(WINDOW_BITS),
        .MIN_ONES   (MIN_ONES)
    ) i_exit_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (st_q.los),
        .hold    (forced),
        .bit_en  (bit_en),
        .is_one  (is_one),
        .long_run(long_run),
        .pass    (win_pass)
    );

    always_comb begin
        st_d = st_q;
        if (forced) begin
            st_d.los = 1'b1;
        end else if (st_q.los) begin
            if (win_pass) begin
                st_d.los = 1'b0;
            end
        end else if (entry_hit) begin
            st_d.los = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.los <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign los_o    = st_q.los;
    assign out_pos  = rx_pos & ~st_q.los;
    assign out_neg  = rx_neg & ~st_q.los;

    generate
        if (STATUS_W > 1) begin : g_status_wide
            assign status_o = {{(STATUS_W-1){1'b0}}, st_q.los};
        end else begin : g_status_one
            assign status_o = st_q.los;
        end
    endgenerate
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk #(
    parameter int unsigned STATUS_W = los_pkg::DEF_STATUS_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_en,
    input logic                rx_pos,
    input logic                rx_neg,
    input logic                max_gain,
    input logic                low_power,
    input logic                out_pos,
    input logic                out_neg,
    input logic                los_o,
    input logic [STATUS_W-1:0] status_o
);
    AST_RESET_FLAG: assert property (@(posedge clk) !rst_n |=> los_o); // R1

    AST_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
        los_o |-> (!out_pos && !out_neg)); // R4

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !los_o |-> (out_pos == rx_pos && out_neg == rx_neg)); // R5

    AST_FORCE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (max_gain || low_power) |=> los_o); // R3

    AST_NO_IDLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_o && !bit_en && !max_gain && !low_power) |=> !los_o); // R10

    AST_NO_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (los_o && !bit_en) |=> los_o); // R6

    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_o) == (los_o ? 1 : 0)); // R9
endmodule

bind los_detector los_detector_chk #(.STATUS_W(STATUS_W)) i_los_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_pos   (rx_pos),
    .rx_neg   (rx_neg),
    .max_gain (max_gain),
    .low_power(low_power),
    .out_pos  (out_pos),
    .out_neg  (out_neg),
    .los_o    (los_o),
    .status_o (status_o)
);

// File: tb/test_los_detector.sv
module test_los_detector;
    localparam int PERIOD = 10;
    localparam int SW     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0, max_gain = 1'b0, low_power = 1'b0;
    logic out_pos, out_neg, los_o;
    logic [SW-1:0] status_o;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    // behavioural model state
    bit m_los = 1'b1;
    int m_run = 0;
    int m_wbits = 0;
    int m_wones = 0;

    always #(PERIOD/2) clk = ~clk;

    los_detector i_los_detector (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .max_gain(max_gain), .low_power(low_power), .out_pos(out_pos), .out_neg(out_neg),
        .los_o(los_o), .status_o(status_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_los = 1'b1; m_run = 0; m_wbits = 0; m_wones = 0;
        end else begin
            bit one;
            bit nxt;
            one = rx_pos || rx_neg;
            nxt = m_los;
            if (bit_en) m_run = one ? 0 : m_run + 1;
            if (max_gain || low_power) begin
                nxt = 1'b1; m_wbits = 0; m_wones = 0;
            end else if (m_los) begin
                if (bit_en) begin
                    if (m_run > 100) begin
                        m_wbits = 0; m_wones = 0;
                    end else begin
                        m_wbits++;
                        if (one) m_wones++;
                        if (m_wbits == 175) begin
                            if (m_wones >= 22) nxt = 1'b0;
                            m_wbits = 0; m_wones = 0;
                        end
                    end
                end
            end else if (bit_en && m_run >= 175) begin
                nxt = 1'b1; m_wbits = 0; m_wones = 0;
            end
            m_los = nxt;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        check(los_o == m_los, cur_req, "los_o", los_o, m_los);
        check(out_pos == (rx_pos && !m_los), m_los ? "R4" : "R5", "out_pos", out_pos, rx_pos && !m_los);
        check(out_neg == (rx_neg && !m_los), m_los ? "R4" : "R5", "out_neg", out_neg, rx_neg && !m_los);
        check(status_o == SW'(m_los), "R9", "status_o", int'(status_o), int'(m_los));
    end

    task automatic step_in();
        @(posedge clk);
        #(PERIOD/4);
    endtask

    // one bit, followed by gap cycles carrying stray ones with bit_en low (R10)
    task automatic send_bit(input bit p, input bit n, input int gaps);
        step_in();
        bit_en = 1'b1; rx_pos = p; rx_neg = n;
        for (int g = 0; g < gaps; g++) begin
            step_in();
            bit_en = 1'b0; rx_pos = 1'b1; rx_neg = 1'b0;
        end
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            step_in();
            bit_en = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
        end
    endtask

    task automatic expect_los(input bit exp, input string req);
        @(negedge clk);
        check(los_o == exp, req, "los_o directed", los_o, exp);
    endtask

    // window of 175 bits: a one every `period` bits, at most `limit` ones
    task automatic send_window(input int period, input int limit, input int last_check);
        int cnt = 0;
        for (int i = 0; i < 175; i++) begin
            bit one;
            one = (i % period == 0) && (cnt < limit);
            if (one) cnt++;
            send_bit(one && (i % 2 == 0), one && (i % 2 == 1), (i % 5 == 0) ? 1 : 0);
            if (i == 173 && last_check) begin
                idle(1);
                expect_los(1'b1, "R6");
            end
        end
        idle(1);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0, (i % 3 == 0) ? 2 : 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        rx_pos = 1'b1; rx_neg = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(los_o == 1'b1, "R1", "los in reset", los_o, 1);
        check(out_pos == 1'b0 && out_neg == 1'b0, "R1", "rails in reset", out_pos, 0);
        #(PERIOD/4);
        rst_n = 1'b1; rx_pos = 1'b0; rx_neg = 1'b0;
        expect_los(1'b1, "R1");

        // R6: passing window clears, not a bit earlier
        cur_req = "R6";
        send_window(8, 175, 1);
        expect_los(1'b0, "R6");

        // R5: pass-through, end with a one
        cur_req = "R5";
        send_bit(1'b0, 1'b1, 0);
        send_bit(1'b1, 1'b0, 0);
        idle(1);

        // R2 / R10: 174 zeros with stray gap ones keep flag low, 175th raises it
        cur_req = "R2";
        send_zeros(174);
        idle(2);
        expect_los(1'b0, "R2");
        send_zeros(1);
        idle(1);
        expect_los(1'b1, "R2");

        // R4: squelch with both rails high
        cur_req = "R4";
        step_in(); rx_pos = 1'b1; rx_neg = 1'b1;
        @(negedge clk);
        check(out_pos == 1'b0 && out_neg == 1'b0, "R4", "squelched rails", out_pos | out_neg, 0);
        idle(1);

        // R8: 21 ones fails, next passing window clears
        cur_req = "R8";
        send_window(8, 21, 0);
        expect_los(1'b1, "R8");
        send_window(8, 175, 0);
        expect_los(1'b0, "R8");

        // R7: re-enter, then a 101+ zero run restarts the window
        cur_req = "R7";
        send_zeros(175);
        idle(1);
        expect_los(1'b1, "R2");
        for (int i = 0; i < 100; i++) send_bit(i % 8 == 0, 1'b0, 0);
        send_zeros(101);
        send_window(8, 175, 1);
        expect_los(1'b0, "R7");

        // R3: max_gain forces loss without a bit
        cur_req = "R3";
        step_in(); max_gain = 1'b1;
        step_in(); max_gain = 1'b0;
        expect_los(1'b1, "R3");

        // R7 boundary: exactly 100 zeros inside a window still passes
        cur_req = "R7";
        for (int i = 0; i < 175; i++) begin
            bit one;
            one = (i == 0) || (i > 100 && (i - 101) % 3 == 0);
            send_bit(one, 1'b0, 0);
        end
        idle(1);
        expect_los(1'b0, "R7");

        // R3: low_power held keeps loss through an otherwise passing window
        cur_req = "R3";
        step_in(); low_power = 1'b1;
        for (int i = 0; i < 175; i++) send_bit(i % 4 == 0, 1'b0, 0);
        idle(1);
        expect_los(1'b1, "R3");
        low_power = 1'b0;
        cur_req = "R6";
        send_window(4, 175, 0);
        expect_los(1'b0, "R6");

        idle(3);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule